// File: doc/BRIEF.md
# Masked Identifier Acceptance Filter

This block decides whether an incoming CAN identifier is accepted by one receive message buffer. Each cycle the receive path can present an identifier with its format flag (standard or extended), together with the index of a candidate buffer and that buffer's stored identifier and format flag. The block answers one cycle later with a valid strobe and a hit flag. Choosing among several buffers that hit is the job of the logic that steps through the buffers.

Which bits take part in the compare is set by three acceptance masks that the CPU can write. Buffer 14 and buffer 15 each have a mask of their own. Every other buffer, from 0 to 31, uses one shared mask. A cleared mask bit makes that identifier bit a don't-care, and a set bit makes it significant. The same masks serve both identifier formats. A standard frame uses only the upper eleven bits of the mask and of the identifier.

The masks may only change while the controller is frozen. A CPU write that arrives outside freeze mode is dropped, so the filter behaves the same way throughout normal operation.

Top module: `id_accept_filter`

## Requirements
- R1: After reset all three masks hold all ones, which gives an exact compare, and `matchValid` and `matchHit` are low.
- R2: When `rxValid` is high in a cycle, `matchValid` is high in the next cycle and carries that compare's result on `matchHit`. When `rxValid` is low, `matchValid` is low in the next cycle.
- R3: A mask bit of 0 makes the identifier bit at that position a don't-care.
- R4: A mask bit of 1 at a position that takes part in the compare requires `rxId` and `bufId` to be equal at that position for a hit.
- R5: When `rxIde` is 0 (standard frame), only bits 28 to 18 of the mask and of the identifiers take part in the compare. Bits 17 to 0 never affect the result.
- R6: When `rxIde` is 1 (extended frame), all 29 bits, 28 to 0, take part under the mask.
- R7: A hit requires `rxIde` to equal `bufIde`, whatever the mask holds.
- R8: Buffer index 14 uses the dedicated mask written with `maskWrSel` = 1. Index 15 uses the one written with `maskWrSel` = 2. Every other index uses the shared mask written with `maskWrSel` = 0. The code 3 writes no mask.
- R9: A mask write (`maskWrEn` high) while `freezeMode` is low leaves every mask unchanged.
- R10: When a mask write and a compare fall in the same cycle, the compare uses the mask value held before that write. The new value applies from the next cycle on.
- R11: `matchHit` is never high while `matchValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| freezeMode | input | 1 | Controller frozen; mask writes allowed only while high |
| maskWrEn | input | 1 | CPU mask write strobe |
| maskWrSel | input | 2 | Mask to write: 0 shared, 1 buffer 14, 2 buffer 15, 3 none |
| maskWrData | input | 29 | Mask value to write |
| rxValid | input | 1 | Compare request for this cycle |
| rxId | input | 29 | Incoming identifier; a standard identifier sits in bits 28 to 18 |
| rxIde | input | 1 | Incoming format: 1 extended, 0 standard |
| bufIdx | input | 5 | Index of the candidate buffer |
| bufId | input | 29 | Identifier stored in the candidate buffer |
| bufIde | input | 1 | Format stored in the candidate buffer |
| matchValid | output | 1 | Result strobe, one cycle after `rxValid` |
| matchHit | output | 1 | The candidate buffer accepts the identifier |

## Verification
A CPU mask write and an acceptance compare can fall in the same cycle. The bench forces this by raising `maskWrEn` and `rxValid` together while the controller is frozen. The compare in that cycle uses a buffer on the shared mask while that mask changes from all zeros to all ones. Its result must be a hit, which reflects the old mask. A second compare of the same identifiers in the next cycle must miss, which shows that the new mask took effect after exactly one cycle.

// File: rtl/idf_pkg.sv
package idf_pkg;

  localparam int ID_W      = 29;
  localparam int STD_W     = 11;
  localparam int NUM_BUF   = 32;
  localparam int BUF_IDX_W = $clog2(NUM_BUF);
  localparam int NUM_MASK  = 3;
  localparam int SEL_W     = $clog2(NUM_MASK + 1);

  localparam int DED_BUF_A = 14;
  localparam int DED_BUF_B = 15;

  // Mask slot numbers; the CPU write select uses the same codes
  localparam int SLOT_SHARED = 0;
  localparam int SLOT_DED_A  = 1;
  localparam int SLOT_DED_B  = 2;

  // Bits that take part in a standard-format compare
  localparam logic [ID_W-1:0] STD_CARE = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  typedef struct packed {
    logic [NUM_MASK-1:0] maskLoad;
    logic [SEL_W-1:0]    maskPick;
    logic                cmpGo;
  } idfStrobe_t;

endpackage

// File: rtl/idf_ctrl.sv
module idf_ctrl
  import idf_pkg::*;
(
  input  logic                 freezeMode,
  input  logic                 maskWrEn,
  input  logic [SEL_W-1:0]     maskWrSel,
  input  logic                 rxValid,
  input  logic [BUF_IDX_W-1:0] bufIdx,
  output idfStrobe_t           strobe
);

  logic wrAllowed;
  assign wrAllowed = freezeMode && maskWrEn;

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_MASK; i++) begin
      strobe.maskLoad[i] = wrAllowed && (maskWrSel == SEL_W'(i));
    end
    if (bufIdx == BUF_IDX_W'(DED_BUF_A)) begin
      strobe.maskPick = SEL_W'(SLOT_DED_A);
    end else if (bufIdx == BUF_IDX_W'(DED_BUF_B)) begin
      strobe.maskPick = SEL_W'(SLOT_DED_B);
    end else begin
      strobe.maskPick = SEL_W'(SLOT_SHARED);
    end
    strobe.cmpGo = rxValid;
  end

endmodule

// File: rtl/idf_datapath.sv
module idf_datapath
  import idf_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  idfStrobe_t      strobe,
  input  logic [ID_W-1:0] maskWrData,
  input  logic [ID_W-1:0] rxId,
  input  logic            rxIde,
  input  logic [ID_W-1:0] bufId,
  input  logic            bufIde,
  output logic            matchValid,
  output logic            matchHit
);

  logic [ID_W-1:0] maskReg [NUM_MASK];
  logic [ID_W-1:0] selMask;
  logic [ID_W-1:0] careMask;
  logic [ID_W-1:0] diffBits;
  logic            hitNow;

  for (genvar g = 0; g < NUM_MASK; g++) begin : gMask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskReg[g] <= '1;
      end else if (strobe.maskLoad[g]) begin
        maskReg[g] <= maskWrData;
      end
    end
  end

  always_comb begin
    selMask = maskReg[SLOT_SHARED];
    for (int i = 0; i < NUM_MASK; i++) begin
      if (strobe.maskPick == SEL_W'(i)) selMask = maskReg[i];
    end
  end

  assign careMask = rxIde ? selMask : (selMask & STD_CARE);
  assign diffBits = (rxId ^ bufId) & careMask;
  assign hitNow   = (rxIde == bufIde) && (diffBits == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchValid <= 1'b0;
      matchHit   <= 1'b0;
    end else begin
      matchValid <= strobe.cmpGo;
      matchHit   <= strobe.cmpGo && hitNow;
    end
  end

endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter
  import idf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 freezeMode,
  input  logic                 maskWrEn,
  input  logic [SEL_W-1:0]     maskWrSel,
  input  logic [ID_W-1:0]      maskWrData,
  input  logic                 rxValid,
  input  logic [ID_W-1:0]      rxId,
  input  logic                 rxIde,
  input  logic [BUF_IDX_W-1:0] bufIdx,
  input  logic [ID_W-1:0]      bufId,
  input  logic                 bufIde,
  output logic                 matchValid,
  output logic                 matchHit
);

  idfStrobe_t strobe;

  idf_ctrl uCtrl (
    .freezeMode (freezeMode),
    .maskWrEn   (maskWrEn),
    .maskWrSel  (maskWrSel),
    .rxValid    (rxValid),
    .bufIdx     (bufIdx),
    .strobe     (strobe)
  );

  idf_datapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .maskWrData (maskWrData),
    .rxId       (rxId),
    .rxIde      (rxIde),
    .bufId      (bufId),
    .bufIde     (bufIde),
    .matchValid (matchValid),
    .matchHit   (matchHit)
  );

endmodule

// File: rtl/idf_checker.sv
module idf_checker
  import idf_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            rxValid,
  input logic [ID_W-1:0] rxId,
  input logic            rxIde,
  input logic [ID_W-1:0] bufId,
  input logic            bufIde,
  input logic            matchValid,
  input logic            matchHit
);

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> matchValid);

  assert_no_stray_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !matchValid);

  assert_format_must_agree_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && (rxIde != bufIde)) |=> !matchHit);

  // Identical identifiers and formats hit under any mask (R3, R4)
  assert_equal_ids_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && (rxIde == bufIde) && (rxId == bufId)) |=> matchHit);

  // Standard compare ignores the lower 18 bits (R5)
  assert_std_low_bits_free_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxIde && !bufIde && (rxId[ID_W-1:ID_W-STD_W] == bufId[ID_W-1:ID_W-STD_W]))
      |=> matchHit);

  assert_hit_needs_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> matchValid);

endmodule

bind id_accept_filter idf_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .rxValid    (rxValid),
  .rxId       (rxId),
  .rxIde      (rxIde),
  .bufId      (bufId),
  .bufIde     (bufIde),
  .matchValid (matchValid),
  .matchHit   (matchHit)
);

// File: tb/id_accept_filter_test.sv
module id_accept_filter_test;
  import idf_pkg::*;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 freezeMode = 1'b0;
  logic                 maskWrEn = 1'b0;
  logic [SEL_W-1:0]     maskWrSel = '0;
  logic [ID_W-1:0]      maskWrData = '0;
  logic                 rxValid = 1'b0;
  logic [ID_W-1:0]      rxId = '0;
  logic                 rxIde = 1'b0;
  logic [BUF_IDX_W-1:0] bufIdx = '0;
  logic [ID_W-1:0]      bufId = '0;
  logic                 bufIde = 1'b0;
  logic                 matchValid;
  logic                 matchHit;

  int checks = 0;
  int errors = 0;

  logic [ID_W-1:0] model [NUM_MASK];
  bit    expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  id_accept_filter uut (
    .clk(clk), .rstN(rstN), .freezeMode(freezeMode), .maskWrEn(maskWrEn),
    .maskWrSel(maskWrSel), .maskWrData(maskWrData), .rxValid(rxValid),
    .rxId(rxId), .rxIde(rxIde), .bufIdx(bufIdx), .bufId(bufId),
    .bufIde(bufIde), .matchValid(matchValid), .matchHit(matchHit)
  );

  function automatic bit expHit(logic [ID_W-1:0] id, logic ide, int idx,
                                logic [ID_W-1:0] bid, logic bide);
    logic [ID_W-1:0] m;
    m = (idx == DED_BUF_A) ? model[1] : (idx == DED_BUF_B) ? model[2] : model[0];
    if (!ide) m = m & 29'h1FFC0000;
    return (ide == bide) && (((id ^ bid) & m) == '0);
  endfunction

  task automatic driveCompare(logic [ID_W-1:0] id, logic ide, int idx,
                              logic [ID_W-1:0] bid, logic bide, string tag);
    @(negedge clk);
    rxValid = 1'b1; rxId = id; rxIde = ide;
    bufIdx = BUF_IDX_W'(idx); bufId = bid; bufIde = bide;
    expQ.push_back(expHit(id, ide, idx, bid, bide));
    tagQ.push_back(tag);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic driveWrite(int sel, logic [ID_W-1:0] data);
    @(negedge clk);
    maskWrEn = 1'b1; maskWrSel = SEL_W'(sel); maskWrData = data;
    if (freezeMode && sel < NUM_MASK) model[sel] = data;
    @(negedge clk);
    maskWrEn = 1'b0;
  endtask

  // R10: write and compare in the same cycle; expectation uses the old mask
  task automatic driveBoth(int sel, logic [ID_W-1:0] data, logic [ID_W-1:0] id,
                           logic ide, int idx, logic [ID_W-1:0] bid, string tag);
    @(negedge clk);
    maskWrEn = 1'b1; maskWrSel = SEL_W'(sel); maskWrData = data;
    rxValid = 1'b1; rxId = id; rxIde = ide;
    bufIdx = BUF_IDX_W'(idx); bufId = bid; bufIde = ide;
    expQ.push_back(expHit(id, ide, idx, bid, ide));
    tagQ.push_back(tag);
    if (freezeMode && sel < NUM_MASK) model[sel] = data;
    @(negedge clk);
    maskWrEn = 1'b0; rxValid = 1'b0;
  endtask

  // Monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rstN) begin
      if (matchValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R2: result with nothing pending, actual matchValid=1 expected 0");
        end else begin
          bit e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (matchHit !== e) begin
            errors++;
            $display("FAIL %s: matchHit actual %0b expected %0b", t, matchHit, e);
          end
        end
      end else if (matchHit) begin
        checks++;
        errors++;
        $display("FAIL R11: matchHit actual 1 expected 0 while matchValid low");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_MASK; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (matchValid !== 1'b0 || matchHit !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs in reset actual %0b%0b expected 00", matchValid, matchHit);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (matchValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: matchValid after reset actual %0b expected 0", matchValid);
    end

    // R1/R6: reset masks compare exactly
    driveCompare(29'h0ABCDEF1, 1'b1, 3, 29'h0ABCDEF1, 1'b1, "R1");
    driveCompare(29'h0ABCDEF1, 1'b1, 3, 29'h0ABCDEF0, 1'b1, "R6");
    driveCompare(29'h0ABCDEF1, 1'b1, 14, 29'h1ABCDEF1, 1'b1, "R6");
    // R5: standard frames only use bits 28..18
    driveCompare(29'h12340000, 1'b0, 3, 29'h1237FFFF, 1'b0, "R5");
    driveCompare(29'h12340000, 1'b0, 3, 29'h12300000, 1'b0, "R5");
    // R7: format must agree
    driveCompare(29'h00000055, 1'b1, 3, 29'h00000055, 1'b0, "R7");
    driveCompare(29'h10000000, 1'b0, 15, 29'h10000000, 1'b1, "R7");

    // Masks written in freeze mode
    freezeMode = 1'b1;
    driveWrite(0, 29'h0);
    driveCompare(29'h1FFFFFFF, 1'b1, 3, 29'h00000000, 1'b1, "R3");
    driveCompare(29'h1FFFFFFF, 1'b1, 14, 29'h1FFFFFFE, 1'b1, "R8");
    driveWrite(1, 29'h00000001);
    driveCompare(29'h00000021, 1'b1, 14, 29'h00000001, 1'b1, "R3");
    driveCompare(29'h00000020, 1'b1, 14, 29'h00000021, 1'b1, "R4");
    driveCompare(29'h00000021, 1'b1, 15, 29'h00000001, 1'b1, "R8");
    driveWrite(2, 29'h1FFC0000);
    driveCompare(29'h0003FFFF, 1'b1, 15, 29'h00000000, 1'b1, "R8");
    driveCompare(29'h00040000, 1'b1, 15, 29'h00000000, 1'b1, "R4");
    driveWrite(3, 29'h15555555);
    driveCompare(29'h1FFFFFFF, 1'b1, 31, 29'h00000000, 1'b1, "R8");

    // R9: writes outside freeze are dropped
    freezeMode = 1'b0;
    driveWrite(0, 29'h1FFFFFFF);
    driveWrite(1, 29'h1FFFFFFF);
    driveCompare(29'h1FFFFFFF, 1'b1, 0, 29'h00000000, 1'b1, "R9");
    driveCompare(29'h00000020, 1'b1, 14, 29'h00000000, 1'b1, "R9");

    // R10: same-cycle write and compare
    freezeMode = 1'b1;
    driveBoth(0, 29'h1FFFFFFF, 29'h00000F00, 1'b1, 16, 29'h00000000, "R10");
    driveCompare(29'h00000F00, 1'b1, 16, 29'h00000000, 1'b1, "R10");
    driveCompare(29'h12345678, 1'b1, 13, 29'h12345678, 1'b1, "R8");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: pending results actual %0d expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule